// File: doc/BRIEF.md
# Escalating Error Signal Monitor

This block supervises one active-high error line coming from a watched processor. While monitoring is enabled and the line is quiet, the block stays idle. When the line goes high, it starts a two-stage escalation, and each stage has its own programmable length counted in ticks of an external prescaler.

In the first stage the block can raise a pin interrupt. If the stage runs out without recovery, it can ask for the driver-enable output to be dropped. Software then gets a second window, in which a fail interrupt may also be raised. If that window also runs out, the block:

- clears the monitoring enable;
- raises its reset bits;
- holds a reset trigger until a sequencer reports that the trigger has been handled.

After that report the block re-initializes. Recovery at any stage needs two things: the error line must have dropped, and software must have cleared the interrupt bits that belong to that stage.

The interrupt bits are cleared by write-one-to-clear strobes. The combined interrupt output is active low. The error line passes through a two-flop synchronizer before the control logic sees it.

Top module: `esc_err_monitor`

## Requirements
- R1: While startEn is 0, the monitor returns to idle and both stage timers restart from zero. An error that is present when startEn returns to 1 begins a fresh first stage.
- R2: When a synchronized error is seen in idle with startEn=1, pinInt is set in the same cycle the first stage starts, unless pinMask=1. The first stage starts in either case.
- R3: The monitor recovers to idle during the first stage once errIn is low and pinInt is clear. It then gives no driver-clear pulse and no reset trigger on later ticks. If pinInt stays set, the stage expires even though errIn is low.
- R4: The first stage expires on tick number max(delay1,1) counted from its start. At expiry drvClrReq pulses high for one cycle, but only when enDrv=1.
- R5: If delay2=0 at first-stage expiry, the reset action (R8) happens in the same cycle as the R4 expiry.
- R6: If delay2 is nonzero, the second stage starts at first-stage expiry. failInt is set at that point unless failMask=1. The reset action follows on the delay2-th tick of the second stage.
- R7: The monitor recovers to idle during the second stage once errIn is low and both pinInt and failInt are clear. No reset trigger follows.
- R8: The reset action does the following. It pulses startClr for one cycle, sets failInt and rstInt, and raises rstTrig. rstTrig stays high until rstDone is seen, after which the monitor is idle. Once startEn is set again, a new error escalates again.
- R9: nIntOut is 0 while any of pinInt, failInt or rstInt is 1, and is 1 otherwise. Each clear strobe clears only its own bit, in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse from the prescaler |
| errIn | input | 1 | Active-high error line, asynchronous |
| startEn | input | 1 | Monitoring enable |
| pinMask | input | 1 | 1 suppresses the pin interrupt |
| failMask | input | 1 | 1 suppresses the fail interrupt |
| enDrv | input | 1 | 1 allows the driver-clear request |
| delay1 | input | 8 | First-stage length in ticks |
| delay2 | input | 8 | Second-stage length in ticks, 0 skips the stage |
| clrPinInt | input | 1 | Write-one-to-clear strobe for pinInt |
| clrFailInt | input | 1 | Write-one-to-clear strobe for failInt |
| clrRstInt | input | 1 | Write-one-to-clear strobe for rstInt |
| rstDone | input | 1 | Sequencer reports the reset trigger was handled |
| pinInt | output | 1 | Pin interrupt bit |
| failInt | output | 1 | Fail interrupt bit |
| rstInt | output | 1 | Reset interrupt bit |
| nIntOut | output | 1 | Active-low combined interrupt |
| drvClrReq | output | 1 | One-cycle request to drop the driver enable |
| startClr | output | 1 | One-cycle request to clear startEn |
| rstTrig | output | 1 | Reset trigger, held until rstDone |

## Verification
A wrong control state becomes visible at the ports on the tick where a stage should expire. If the stage counter is stuck or was not restarted, drvClrReq or rstTrig arrives a tick early, arrives late, or never arrives. The bench counts ticks from the start of each stage, so an off-by-one timer shows as a mismatched tick index. A recovery test that is mishandled shows within a few ticks, either as a pulse that should be absent or as nIntOut staying low after the clears.

// File: rtl/esm_pkg.sv
`timescale 1ns/1ps
package esm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STAGE1 = 2'd1,
    ST_STAGE2 = 2'd2,
    ST_RESET  = 2'd3
  } esm_state_t;

  typedef struct packed {
    logic cntClr;
    logic cntRun;
    logic setPin;
    logic setFail;
    logic setRst;
    logic pulseDrv;
    logic pulseStart;
  } esm_strobe_t;
endpackage

// File: rtl/esm_datapath.sv
`timescale 1ns/1ps
module esm_datapath
  import esm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             errIn,
  input  logic [CNT_W-1:0] delay1,
  input  logic [CNT_W-1:0] delay2,
  input  logic             clrPin,
  input  logic             clrFail,
  input  logic             clrRst,
  input  esm_strobe_t      ctl,
  input  logic             useDelay2,
  output logic             errSync,
  output logic             cntDone,
  output logic             pinInt,
  output logic             failInt,
  output logic             rstInt,
  output logic             nInt,
  output logic             drvClrReq,
  output logic             startClr
);
  localparam int EXT_W = CNT_W + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       limit;
  logic [EXT_W-1:0]       cntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], errIn};
  end
  assign errSync = syncQ[SYNC_STAGES-1];

  assign limit   = useDelay2 ? delay2 : delay1;
  assign cntNext = {1'b0, cnt} + EXT_W'(1);
  assign cntDone = tick && (cntNext >= {1'b0, limit});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    cnt <= '0;
    else if (ctl.cntClr)          cnt <= '0;
    else if (ctl.cntRun && tick)  cnt <= cntNext[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinInt    <= 1'b0;
      failInt   <= 1'b0;
      rstInt    <= 1'b0;
      drvClrReq <= 1'b0;
      startClr  <= 1'b0;
    end else begin
      pinInt    <= (pinInt  & ~clrPin)  | ctl.setPin;
      failInt   <= (failInt & ~clrFail) | ctl.setFail;
      rstInt    <= (rstInt  & ~clrRst)  | ctl.setRst;
      drvClrReq <= ctl.pulseDrv;
      startClr  <= ctl.pulseStart;
    end
  end

  assign nInt = ~(pinInt | failInt | rstInt);
endmodule

// File: rtl/esm_control.sv
`timescale 1ns/1ps
module esm_control
  import esm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startEn,
  input  logic             pinMask,
  input  logic             failMask,
  input  logic             enDrv,
  input  logic [CNT_W-1:0] delay2,
  input  logic             errSync,
  input  logic             cntDone,
  input  logic             pinInt,
  input  logic             failInt,
  input  logic             rstDone,
  output esm_strobe_t      ctl,
  output logic             useDelay2,
  output logic             rstTrig
);
  esm_state_t state, stateNext;
  logic skipStage2;

  assign skipStage2 = (delay2 == '0);
  assign useDelay2  = (state == ST_STAGE2);
  assign rstTrig    = (state == ST_RESET);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        ctl.cntClr = 1'b1;
        if (startEn && errSync) begin
          stateNext  = ST_STAGE1;
          ctl.setPin = ~pinMask;
        end
      end
      ST_STAGE1: begin
        ctl.cntRun = 1'b1;
        if (!startEn || (!errSync && !pinInt)) begin
          stateNext  = ST_IDLE;
          ctl.cntClr = 1'b1;
        end else if (cntDone) begin
          ctl.pulseDrv = enDrv;
          ctl.cntClr   = 1'b1;
          if (skipStage2) begin
            stateNext      = ST_RESET;
            ctl.setFail    = 1'b1;
            ctl.setRst     = 1'b1;
            ctl.pulseStart = 1'b1;
          end else begin
            stateNext   = ST_STAGE2;
            ctl.setFail = ~failMask;
          end
        end
      end
      ST_STAGE2: begin
        ctl.cntRun = 1'b1;
        if (!startEn || (!errSync && !pinInt && !failInt)) begin
          stateNext  = ST_IDLE;
          ctl.cntClr = 1'b1;
        end else if (cntDone) begin
          stateNext      = ST_RESET;
          ctl.cntClr     = 1'b1;
          ctl.setFail    = 1'b1;
          ctl.setRst     = 1'b1;
          ctl.pulseStart = 1'b1;
        end
      end
      ST_RESET: begin
        ctl.cntClr = 1'b1;
        if (rstDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/esc_err_monitor.sv
`timescale 1ns/1ps
module esc_err_monitor
  import esm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             errIn,
  input  logic             startEn,
  input  logic             pinMask,
  input  logic             failMask,
  input  logic             enDrv,
  input  logic [CNT_W-1:0] delay1,
  input  logic [CNT_W-1:0] delay2,
  input  logic             clrPinInt,
  input  logic             clrFailInt,
  input  logic             clrRstInt,
  input  logic             rstDone,
  output logic             pinInt,
  output logic             failInt,
  output logic             rstInt,
  output logic             nIntOut,
  output logic             drvClrReq,
  output logic             startClr,
  output logic             rstTrig
);
  esm_strobe_t ctl;
  logic useDelay2, errSync, cntDone;

  esm_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .errIn(errIn),
    .delay1(delay1), .delay2(delay2),
    .clrPin(clrPinInt), .clrFail(clrFailInt), .clrRst(clrRstInt),
    .ctl(ctl), .useDelay2(useDelay2),
    .errSync(errSync), .cntDone(cntDone),
    .pinInt(pinInt), .failInt(failInt), .rstInt(rstInt), .nInt(nIntOut),
    .drvClrReq(drvClrReq), .startClr(startClr)
  );

  esm_control #(.CNT_W(CNT_W)) i_ctl (
    .clk(clk), .rstN(rstN), .startEn(startEn), .pinMask(pinMask),
    .failMask(failMask), .enDrv(enDrv), .delay2(delay2),
    .errSync(errSync), .cntDone(cntDone), .pinInt(pinInt),
    .failInt(failInt), .rstDone(rstDone),
    .ctl(ctl), .useDelay2(useDelay2), .rstTrig(rstTrig)
  );
endmodule

// File: rtl/esm_checker.sv
`timescale 1ns/1ps
module esm_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startEn,
  input logic             enDrv,
  input logic [CNT_W-1:0] delay2,
  input logic             rstDone,
  input logic             pinInt,
  input logic             failInt,
  input logic             rstInt,
  input logic             nIntOut,
  input logic             drvClrReq,
  input logic             startClr,
  input logic             rstTrig
);
  a_r1_trig_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstTrig) |-> $past(startEn));
  a_r4_drv_needs_endrv: assert property (@(posedge clk) disable iff (!rstN)
    drvClrReq |-> $past(enDrv));
  a_r4_drv_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    drvClrReq |=> !drvClrReq);
  a_r5_skip_stage2: assert property (@(posedge clk) disable iff (!rstN)
    (drvClrReq && $past(delay2) == '0) |-> rstTrig);
  a_r8_startclr_with_bits: assert property (@(posedge clk) disable iff (!rstN)
    startClr |-> (rstTrig && rstInt && failInt));
  a_r8_trig_held: assert property (@(posedge clk) disable iff (!rstN)
    (rstTrig && !rstDone) |=> rstTrig);
  a_r9_pin_lowers_nint: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinInt) |-> !nIntOut);
endmodule

bind esc_err_monitor esm_checker #(.CNT_W(CNT_W)) i_esm_checker (
  .clk(clk), .rstN(rstN), .startEn(startEn), .enDrv(enDrv), .delay2(delay2),
  .rstDone(rstDone), .pinInt(pinInt), .failInt(failInt), .rstInt(rstInt),
  .nIntOut(nIntOut), .drvClrReq(drvClrReq), .startClr(startClr),
  .rstTrig(rstTrig)
);

// File: tb/test_esc_err_monitor.sv
`timescale 1ns/1ps
module test_esc_err_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, errIn = 1'b0, startEn = 1'b0;
  logic pinMask = 1'b0, failMask = 1'b0, enDrv = 1'b0;
  logic [7:0] delay1 = 8'd0, delay2 = 8'd0;
  logic clrPinInt = 1'b0, clrFailInt = 1'b0, clrRstInt = 1'b0, rstDone = 1'b0;
  logic pinInt, failInt, rstInt, nIntOut, drvClrReq, startClr, rstTrig;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  esc_err_monitor i_esc_err_monitor (
    .clk(clk), .rstN(rstN), .tick(tick), .errIn(errIn), .startEn(startEn),
    .pinMask(pinMask), .failMask(failMask), .enDrv(enDrv),
    .delay1(delay1), .delay2(delay2),
    .clrPinInt(clrPinInt), .clrFailInt(clrFailInt), .clrRstInt(clrRstInt),
    .rstDone(rstDone), .pinInt(pinInt), .failInt(failInt), .rstInt(rstInt),
    .nIntOut(nIntOut), .drvClrReq(drvClrReq), .startClr(startClr),
    .rstTrig(rstTrig)
  );

  typedef struct packed {
    logic       pm;
    logic       fm;
    logic       ed;
    logic [7:0] d1;
    logic [7:0] d2;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{pm:1'b0, fm:1'b0, ed:1'b1, d1:8'd3, d2:8'd4},
    '{pm:1'b1, fm:1'b0, ed:1'b1, d1:8'd2, d2:8'd0},
    '{pm:1'b0, fm:1'b1, ed:1'b0, d1:8'd0, d2:8'd3},
    '{pm:1'b0, fm:1'b0, ed:1'b1, d1:8'd1, d2:8'd1},
    '{pm:1'b1, fm:1'b1, ed:1'b1, d1:8'd5, d2:8'd2},
    '{pm:1'b0, fm:1'b0, ed:1'b0, d1:8'd0, d2:8'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic tickOnce();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic clearAll();
    @(negedge clk) begin clrPinInt = 1'b1; clrFailInt = 1'b1; clrRstInt = 1'b1; end
    @(negedge clk) begin clrPinInt = 1'b0; clrFailInt = 1'b0; clrRstInt = 1'b0; end
  endtask

  task automatic handshake();
    @(negedge clk) rstDone = 1'b1;
    @(negedge clk) rstDone = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int drvAt, trigAt, e1, expTrig;
    int failAtE1, stSeen, expDrv, expFail;
    bit sawDrv;

    cyc(3);
    chk("reset nIntOut R9", nIntOut, 1);
    chk("reset rstTrig R8", rstTrig, 0);
    chk("reset drvClrReq R4", drvClrReq, 0);
    chk("reset pinInt R2", pinInt, 0);
    @(negedge clk) rstN = 1'b1;
    startEn = 1'b1;
    cyc(2);

    // Table walk: full escalation with the error held and no clears
    for (int v = 0; v < NVEC; v++) begin
      pinMask = VECS[v].pm; failMask = VECS[v].fm; enDrv = VECS[v].ed;
      delay1 = VECS[v].d1; delay2 = VECS[v].d2;
      startEn = 1'b1;
      errIn = 1'b1;
      cyc(4);
      chk($sformatf("v%0d pinInt R2", v), pinInt, VECS[v].pm ? 0 : 1);
      chk($sformatf("v%0d nIntOut R9", v), nIntOut, VECS[v].pm ? 1 : 0);
      e1 = (VECS[v].d1 == 0) ? 1 : int'(VECS[v].d1);
      expTrig = e1 + int'(VECS[v].d2);
      drvAt = 0; trigAt = 0; failAtE1 = -1; stSeen = 0;
      for (int i = 1; i <= 600; i++) begin
        tickOnce();
        if (drvClrReq && drvAt == 0) drvAt = i;
        if (i == e1) failAtE1 = int'(failInt);
        if (rstTrig) begin
          trigAt = i;
          stSeen = int'(startClr);
          break;
        end
      end
      expDrv = VECS[v].ed ? e1 : 0;
      chk($sformatf("v%0d drv tick R4", v), drvAt, expDrv);
      expFail = (VECS[v].d2 == 0) ? 1 : (VECS[v].fm ? 0 : 1);
      chk($sformatf("v%0d failInt at stage-1 end R6", v), failAtE1, expFail);
      chk($sformatf("v%0d trigger tick R5 R6", v), trigAt, expTrig);
      chk($sformatf("v%0d startClr R8", v), stSeen, 1);
      chk($sformatf("v%0d rstInt R8", v), int'(rstInt), 1);
      startEn = 1'b0;
      cyc(5);
      chk($sformatf("v%0d trigger held R8", v), int'(rstTrig), 1);
      handshake();
      chk($sformatf("v%0d trigger released R8", v), int'(rstTrig), 0);
      errIn = 1'b0;
      cyc(4);
      clearAll();
      chk($sformatf("v%0d nIntOut after clear R9", v), int'(nIntOut), 1);
    end

    // First-stage recovery after the error drops and pinInt is cleared
    pinMask = 1'b0; failMask = 1'b0; enDrv = 1'b1; delay1 = 8'd4; delay2 = 8'd3;
    startEn = 1'b1;
    errIn = 1'b1; cyc(4);
    errIn = 1'b0; cyc(3);
    @(negedge clk) clrPinInt = 1'b1;
    @(negedge clk) clrPinInt = 1'b0;
    cyc(2);
    chk("stage-1 recovery nIntOut R3", int'(nIntOut), 1);
    sawDrv = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tickOnce();
      if (drvClrReq || rstTrig) sawDrv = 1'b1;
    end
    chk("stage-1 recovery no escalation R3", int'(sawDrv), 0);

    // Error gone but pinInt left set: the first stage still expires
    errIn = 1'b1; cyc(4);
    errIn = 1'b0; cyc(4);
    drvAt = 0;
    for (int i = 1; i <= 4; i++) begin
      tickOnce();
      if (drvClrReq && drvAt == 0) drvAt = i;
    end
    chk("uncleared pinInt expiry R3", drvAt, 4);
    chk("stage-2 failInt R6", int'(failInt), 1);

    // Second-stage recovery
    @(negedge clk) begin clrPinInt = 1'b1; clrFailInt = 1'b1; end
    @(negedge clk) begin clrPinInt = 1'b0; clrFailInt = 1'b0; end
    cyc(2);
    chk("stage-2 recovery nIntOut R7", int'(nIntOut), 1);
    sawDrv = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tickOnce();
      if (rstTrig) sawDrv = 1'b1;
    end
    chk("stage-2 recovery no trigger R7", int'(sawDrv), 0);

    // Dropping startEn mid-stage restarts the timer
    errIn = 1'b1; cyc(4);
    tickOnce(); tickOnce();
    @(negedge clk) startEn = 1'b0;
    cyc(2);
    startEn = 1'b1;
    cyc(4);
    drvAt = 0;
    for (int i = 1; i <= 4; i++) begin
      tickOnce();
      if (drvClrReq && drvAt == 0) drvAt = i;
    end
    chk("timer restart after startEn low R1", drvAt, 4);
    trigAt = 0;
    for (int i = 1; i <= 3; i++) begin
      tickOnce();
      if (rstTrig && trigAt == 0) trigAt = i;
    end
    chk("trigger after restarted escalation R6", trigAt, 3);

    // Each clear strobe touches only its own bit
    @(negedge clk) clrRstInt = 1'b1;
    @(negedge clk) clrRstInt = 1'b0;
    chk("clrRstInt clears rstInt R9", int'(rstInt), 0);
    chk("clrRstInt keeps failInt R9", int'(failInt), 1);
    chk("nIntOut low with failInt R9", int'(nIntOut), 0);
    @(negedge clk) clrFailInt = 1'b1;
    @(negedge clk) clrFailInt = 1'b0;
    chk("clrFailInt keeps pinInt R9", int'(pinInt), 1);
    chk("nIntOut low with pinInt R9", int'(nIntOut), 0);
    @(negedge clk) clrPinInt = 1'b1;
    @(negedge clk) clrPinInt = 1'b0;
    chk("all clear nIntOut R9", int'(nIntOut), 1);
    startEn = 1'b0;
    handshake();
    chk("handshake returns idle R8", int'(rstTrig), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule